// File: doc/BRIEF.md
# Converter Serial Data Port with Control Registers

This block is the slave-side digital serial port of an audio or modem converter. A host drives the shift clock and an active-low frame sync. Each frame moves one 16-bit word in each direction, most significant bit first. Outgoing bits change on the rising clock edge and incoming bits are captured on the falling clock edge. There are two kinds of frame. Primary frames carry two's-complement samples: the ADC sample bus goes out, and the received word is put on a parallel DAC bus with a one-cycle strobe. Secondary frames read and write a small file of control registers. Their fields drive the rest of the chip: loopback, resolution modes, input select, gain, rate divider, PLL bypass and a general-purpose flag pin.

A secondary frame is requested at the end of a primary frame, in one of two ways. Either the request pin is high at the last clock of that frame, or the DAC path is in 15+1-bit mode and the received word has its least significant bit set. The frame after such a request is then treated as secondary; the host normally places it half a sample period later. The upper byte of a secondary word is a header: a two-bit prefix that must be 00, a read bit, and a five-bit register address. The lower byte is write data. Because the header arrives first, read data is returned in the lower half of the same frame.

The block is clocked directly by the shift clock. Clock and frame generation, filters and the analog paths are outside it.

Top module: `codec_port`

## Requirements
- R1: A frame starts when fs_ni goes low. dout_o shows word bit 15 before the first rising sclk_i edge and moves to the next lower bit after each rising edge. din_i is captured on each falling edge, MSB first. A frame is exactly 16 rising edges long.
- R2: dout_oe_o is high exactly while fs_ni is low; dout_o is 0 whenever dout_oe_o is low.
- R3: A primary frame sends adc_data_i as sampled at the last rising edge before fs_ni falls. In ADC 15+1 mode (adc_full_o = 0, register 2 bit 1 clear, the reset value), bit 0 is sent as 0.
- R4: At the 16th rising edge of a primary frame, dac_data_o takes the received word and dac_strb_o is high for exactly one cycle. In DAC 15+1 mode (dac_full_o = 0, register 1 bit 1 clear), bit 0 of dac_data_o is forced to 0.
- R5: If fc_i is high at the 16th rising edge of a primary frame, the next frame is secondary.
- R6: In DAC 15+1 mode, a received primary word with bit 0 = 1 makes the next frame secondary. In 16-bit DAC mode, that bit requests nothing.
- R7: A secondary word whose bits 15:13 are 000 writes bits 7:0 into the register addressed by bits 12:8, at the end of the frame. Valid addresses are 1 to 4. If bits 15:14 are not 00, the word is ignored.
- R8: A secondary word whose bits 15:13 are 001 returns the addressed register, as it was before any write, on dout_o bits 7:0, with bits 15:8 sent as 0. Addresses 0 and 5 to 31 read as 0. With no read request, all 16 bits are sent as 0.
- R9: Writes to address 0 (no-op), to 5 and 6 (reserved), and to 7 to 31 change no register.
- R10: A secondary frame neither updates the DAC bus nor requests a further secondary frame.
- R11: With register 1 bit 0 set (digital loopback), a primary frame sends the current dac_data_o value in place of adc_data_i. The R3 masking still applies.
- R12: The outputs decode the registers as follows. Register 1: bit 0 to dig_loop_o, bit 1 to dac_full_o, bit 2 to aux_sel_o. Register 2: bit 0 to flag_o, bit 1 to adc_full_o, bit 2 to ana_loop_o. Register 3 goes to chain_cfg_o. Register 4: bits 6:3 to gain_sel_o, bit 7 to pll_bypass_o, and rate_div_o = bits 2:0 plus 1.
- R13: Writing register 1 with bit 7 set returns every register to its reset value. Register 1 bit 7 always reads 0.
- R14: After rst_ni, all registers are 0, dac_data_o is 0, dac_strb_o is 0 and the first frame is primary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Shift clock from the host |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_ni | input | 1 | Frame sync, active low |
| din_i | input | 1 | Serial data from the host |
| fc_i | input | 1 | Secondary frame request pin |
| adc_data_i | input | 16 | ADC sample to be sent |
| dout_o | output | 1 | Serial data to the host |
| dout_oe_o | output | 1 | Output enable for dout_o (pad driver) |
| dac_data_o | output | 16 | Received DAC sample |
| dac_strb_o | output | 1 | One-cycle strobe on a DAC update |
| flag_o | output | 1 | General-purpose flag from register 2 |
| dig_loop_o | output | 1 | Digital loopback enable |
| ana_loop_o | output | 1 | Analog loopback enable |
| aux_sel_o | output | 1 | Auxiliary input select |
| adc_full_o | output | 1 | ADC 16-bit mode (0 = 15+1) |
| dac_full_o | output | 1 | DAC 16-bit mode (0 = 15+1) |
| gain_sel_o | output | 4 | Amplifier gain field |
| rate_div_o | output | 4 | Sample-rate divider N (1 to 8) |
| pll_bypass_o | output | 1 | PLL bypass select |
| chain_cfg_o | output | 8 | Frame delay and chain configuration byte |

## Verification
The assertions assume that the host keeps fs_ni low for exactly 16 rising edges per frame, with at least one idle edge between frames, and that din_i and fs_ni change only away from the sclk_i edges. The strobe and DAC-hold properties rely on this framing. The bench drives fs_ni, din_i and fc_i a fifth of a period after each rising edge, and keeps a gap of idle clocks between frames. It orders secondary frames only where its own model expects them, so the design and the model always agree on the frame kind.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned REG_W    = WORD_W / 2;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned NUM_CTRL = 4;

  // register addresses
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ANA   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CHAIN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(4);

  // header byte of a secondary word: {prefix[1:0], rd, addr[4:0]}
  localparam int unsigned HDR_RD_BIT = ADDR_W;

  // field positions
  localparam int unsigned MODE_DLOOP = 0;
  localparam int unsigned MODE_DAC16 = 1;
  localparam int unsigned MODE_AUX   = 2;
  localparam int unsigned MODE_SRST  = 7;
  localparam int unsigned ANA_FLAG   = 0;
  localparam int unsigned ANA_ADC16  = 1;
  localparam int unsigned ANA_ALOOP  = 2;
  localparam int unsigned CLK_PLLBY  = 7;

  typedef struct packed {
    logic       dig_loop;
    logic       dac_full;
    logic       aux_sel;
    logic       flag;
    logic       adc_full;
    logic       ana_loop;
    logic [7:0] chain;
    logic [3:0] gain;
    logic [2:0] rate_sel;
    logic       pll_bypass;
  } cfg_t;
endpackage

// File: rtl/codec_port_shift.sv
module codec_port_shift #(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fs_ni,
  input  logic           din_i,
  input  logic [W-1:0]   load_word_i,
  input  logic           mid_load_i,
  input  logic [W/2-1:0] mid_byte_i,
  output logic           dout_o,
  output logic           dout_oe_o,
  output logic [W-1:0]   rx_word_o,
  output logic           mid_o,
  output logic           done_o
);
  localparam int unsigned HALF = W / 2;
  localparam int unsigned CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  tx_q;
  logic [W-1:0]  rx_q;

  assign mid_o     = !fs_ni && (cnt_q == MID);
  assign done_o    = !fs_ni && (cnt_q == LAST);
  assign dout_oe_o = !fs_ni;
  assign dout_o    = dout_oe_o & tx_q[W-1];
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (fs_ni) cnt_q <= '0;
    else            cnt_q <= cnt_q + CW'(1);
  end

  // idle: keep next word staged so bit W-1 is ready when fs falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tx_q <= '0;
    else if (fs_ni)              tx_q <= load_word_i;
    else if (mid_o && mid_load_i) tx_q <= {mid_byte_i, {HALF{1'b0}}};
    else                         tx_q <= {tx_q[W-2:0], 1'b0};
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (!fs_ni) rx_q <= {rx_q[W-2:0], din_i};
  end
endmodule

// File: rtl/codec_port_regs.sv
module codec_port_regs
  import codec_port_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NR = NUM_CTRL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [RW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [RW-1:0] rd_data_o,
  output cfg_t          cfg_o
);
  logic [NR*RW-1:0] flat;
  logic             soft_rst;

  assign soft_rst = wr_en_i && (wr_addr_i == AW'(A_MODE)) && wr_data_i[MODE_SRST];

  for (genvar i = 1; i <= int'(NR); i++) begin : g_reg
    localparam logic [RW-1:0] KEEP = (i == int'(A_MODE)) ? ~(RW'(1) << MODE_SRST) : '1;
    logic [RW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  q <= '0;
      else if (soft_rst)                            q <= '0;
      else if (wr_en_i && (wr_addr_i == AW'(i)))    q <= wr_data_i & KEEP;
    end
    assign flat[i*RW-1 -: RW] = q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 1; i <= int'(NR); i++)
      if (rd_addr_i == AW'(i)) rd_data_o = flat[i*RW-1 -: RW];
  end

  logic [RW-1:0] r_mode, r_ana, r_chain, r_clk;
  assign r_mode  = flat[int'(A_MODE)*RW-1  -: RW];
  assign r_ana   = flat[int'(A_ANA)*RW-1   -: RW];
  assign r_chain = flat[int'(A_CHAIN)*RW-1 -: RW];
  assign r_clk   = flat[int'(A_CLK)*RW-1   -: RW];

  always_comb begin
    cfg_o.dig_loop   = r_mode[MODE_DLOOP];
    cfg_o.dac_full   = r_mode[MODE_DAC16];
    cfg_o.aux_sel    = r_mode[MODE_AUX];
    cfg_o.flag       = r_ana[ANA_FLAG];
    cfg_o.adc_full   = r_ana[ANA_ADC16];
    cfg_o.ana_loop   = r_ana[ANA_ALOOP];
    cfg_o.chain      = r_chain[7:0];
    cfg_o.rate_sel   = r_clk[2:0];
    cfg_o.gain       = r_clk[6:3];
    cfg_o.pll_bypass = r_clk[CLK_PLLBY];
  end

  logic unused;
  assign unused = ^{r_mode[RW-1:3], r_ana[RW-1:3]};
endmodule

// File: rtl/codec_port.sv
module codec_port
  import codec_port_pkg::*;
(
  input  logic        sclk_i,
  input  logic        rst_ni,
  input  logic        fs_ni,
  input  logic        din_i,
  input  logic        fc_i,
  input  logic [15:0] adc_data_i,
  output logic        dout_o,
  output logic        dout_oe_o,
  output logic [15:0] dac_data_o,
  output logic        dac_strb_o,
  output logic        flag_o,
  output logic        dig_loop_o,
  output logic        ana_loop_o,
  output logic        aux_sel_o,
  output logic        adc_full_o,
  output logic        dac_full_o,
  output logic [3:0]  gain_sel_o,
  output logic [3:0]  rate_div_o,
  output logic        pll_bypass_o,
  output logic [7:0]  chain_cfg_o
);
  localparam int unsigned W    = WORD_W;
  localparam int unsigned HALF = REG_W;

  cfg_t          cfg;
  logic          sec_q, strb_q;
  logic [W-1:0]  dac_q, rx_word, src, prim_word, load_word;
  logic [HALF-1:0] hdr_mid, hdr_done, rd_data, mid_byte;
  logic          mid, done, rd_ok, wr_en;

  assign src       = cfg.dig_loop ? dac_q : adc_data_i;
  assign prim_word = cfg.adc_full ? src : {src[W-1:1], 1'b0};
  assign load_word = sec_q ? '0 : prim_word;

  // header sits in the low byte at mid-frame, in the high byte at the end
  assign hdr_mid  = rx_word[HALF-1:0];
  assign hdr_done = rx_word[W-1:HALF];
  assign rd_ok    = (hdr_mid[HALF-1:HALF-2] == 2'b00) && hdr_mid[HDR_RD_BIT];
  assign mid_byte = rd_ok ? rd_data : '0;
  assign wr_en    = done && sec_q && (hdr_done[HALF-1:HALF-3] == 3'b000);

  codec_port_shift #(.W(W)) u_shift (
    .clk_i       (sclk_i),
    .rst_ni      (rst_ni),
    .fs_ni       (fs_ni),
    .din_i       (din_i),
    .load_word_i (load_word),
    .mid_load_i  (sec_q),
    .mid_byte_i  (mid_byte),
    .dout_o      (dout_o),
    .dout_oe_o   (dout_oe_o),
    .rx_word_o   (rx_word),
    .mid_o       (mid),
    .done_o      (done)
  );

  codec_port_regs u_regs (
    .clk_i     (sclk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (hdr_done[ADDR_W-1:0]),
    .wr_data_i (rx_word[HALF-1:0]),
    .rd_addr_i (hdr_mid[ADDR_W-1:0]),
    .rd_data_o (rd_data),
    .cfg_o     (cfg)
  );

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 1'b0;
      dac_q  <= '0;
      strb_q <= 1'b0;
    end else begin
      strb_q <= 1'b0;
      if (done) begin
        if (sec_q) begin
          sec_q <= 1'b0;
        end else begin
          dac_q  <= cfg.dac_full ? rx_word : {rx_word[W-1:1], 1'b0};
          strb_q <= 1'b1;
          sec_q  <= fc_i | (!cfg.dac_full & rx_word[0]);
        end
      end
    end
  end

  logic unused;
  assign unused = mid ^ ^hdr_done[HALF-4:ADDR_W];

  assign dac_data_o   = dac_q;
  assign dac_strb_o   = strb_q;
  assign flag_o       = cfg.flag;
  assign dig_loop_o   = cfg.dig_loop;
  assign ana_loop_o   = cfg.ana_loop;
  assign aux_sel_o    = cfg.aux_sel;
  assign adc_full_o   = cfg.adc_full;
  assign dac_full_o   = cfg.dac_full;
  assign gain_sel_o   = cfg.gain;
  assign rate_div_o   = {1'b0, cfg.rate_sel} + 4'd1;
  assign pll_bypass_o = cfg.pll_bypass;
  assign chain_cfg_o  = cfg.chain;
endmodule

// File: rtl/codec_port_chk.sv
module codec_port_chk (
  input logic        sclk_i,
  input logic        rst_ni,
  input logic        fs_ni,
  input logic        dout_o,
  input logic        dout_oe_o,
  input logic [15:0] dac_data_o,
  input logic        dac_strb_o,
  input logic        dac_full_o,
  input logic [3:0]  rate_div_o
);
  p_oe_idle_r2: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    fs_ni |-> !dout_oe_o);
  p_dout_quiet_r2: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !dout_oe_o |-> !dout_o);
  p_strb_single_r4: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    dac_strb_o |=> !dac_strb_o);
  p_strb_in_frame_r4: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    $rose(dac_strb_o) |-> $past(!fs_ni));
  p_dac_lsb_r4: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (dac_strb_o && !dac_full_o) |-> !dac_data_o[0]);
  p_dac_hold_r10: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    !$stable(dac_data_o) |-> dac_strb_o);
  p_rate_range_r12: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (rate_div_o != 4'd0) && (rate_div_o <= 4'd8));
endmodule

bind codec_port codec_port_chk u_chk (
  .sclk_i     (sclk_i),
  .rst_ni     (rst_ni),
  .fs_ni      (fs_ni),
  .dout_o     (dout_o),
  .dout_oe_o  (dout_oe_o),
  .dac_data_o (dac_data_o),
  .dac_strb_o (dac_strb_o),
  .dac_full_o (dac_full_o),
  .rate_div_o (rate_div_o)
);

// File: tb/codec_port_test.sv
module codec_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 20;

  logic sclk = 1'b0, rst_n = 1'b0, fs_n = 1'b1, din = 1'b0, fc = 1'b0;
  logic [15:0] adc_val = '0;
  logic dout, dout_oe, dac_strb, flag, dloop, aloop, aux, adc16, dac16, pllby;
  logic [15:0] dac_data;
  logic [3:0]  gain, rdiv;
  logic [7:0]  chain;

  int tests = 0, fails = 0;
  bit run = 0, finished = 0;

  // reference model
  logic [7:0]  m_reg [0:7];
  logic [15:0] m_dac = '0;
  logic        m_strb = 0, m_sec = 0;

  always #(CLK_PERIOD/2) sclk = ~sclk;

  codec_port uut (
    .sclk_i(sclk), .rst_ni(rst_n), .fs_ni(fs_n), .din_i(din), .fc_i(fc),
    .adc_data_i(adc_val), .dout_o(dout), .dout_oe_o(dout_oe),
    .dac_data_o(dac_data), .dac_strb_o(dac_strb), .flag_o(flag),
    .dig_loop_o(dloop), .ana_loop_o(aloop), .aux_sel_o(aux),
    .adc_full_o(adc16), .dac_full_o(dac16), .gain_sel_o(gain),
    .rate_div_o(rdiv), .pll_bypass_o(pllby), .chain_cfg_o(chain)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge sclk) begin
    #7;
    if (run && !finished) begin
      chk("R2 oe", 16'(dout_oe), 16'(!fs_n));
      if (!dout_oe) chk("R2 quiet", 16'(dout), 16'h0);
      chk("R4 dac", dac_data, m_dac);
      chk("R4 strb", 16'(dac_strb), 16'(m_strb));
      chk("R12 mode", {13'h0, aux, dac16, dloop}, {13'h0, m_reg[1][2:0]});
      chk("R12 ana", {13'h0, aloop, adc16, flag}, {13'h0, m_reg[2][2:0]});
      chk("R12 chain", 16'(chain), 16'(m_reg[3]));
      chk("R12 clk", {7'h0, pllby, gain, rdiv},
          {7'h0, m_reg[4][7], m_reg[4][6:3], 4'(m_reg[4][2:0]) + 4'd1});
    end
  end

  task automatic do_frame(input logic [15:0] w, input logic req, input string tag);
    logic [15:0] exp, src;
    logic [4:0]  a;
    logic [7:0]  rv;
    logic        sec;
    sec = m_sec;
    if (!sec) begin
      src = m_reg[1][0] ? m_dac : adc_val;
      exp = m_reg[2][1] ? src : (src & 16'hFFFE);
    end else begin
      a   = w[12:8];
      rv  = (a >= 5'd1 && a <= 5'd4) ? m_reg[a] : 8'h00;
      exp = (w[15:13] == 3'b001) ? {8'h00, rv} : 16'h0000;
    end
    @(posedge sclk); #2;
    fc = req; fs_n = 1'b0; din = w[15];
    for (int k = 0; k < 16; k++) begin
      #5;
      chk($sformatf("%s R1 bit%0d", tag, 15 - k), 16'(dout), 16'(exp[15-k]));
      @(posedge sclk); #2;
      if (k < 15) din = w[14-k];
    end
    fs_n = 1'b1; din = 1'b0;
    if (!sec) begin
      m_dac  = m_reg[1][1] ? w : (w & 16'hFFFE);
      m_strb = 1'b1;
      m_sec  = req | (!m_reg[1][1] & w[0]);
    end else begin
      m_sec = 1'b0;
      if (w[15:13] == 3'b000) begin
        a = w[12:8];
        if (a == 5'd1 && w[7]) begin
          for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        end else if (a >= 5'd1 && a <= 5'd4) begin
          m_reg[a] = (a == 5'd1) ? (w[7:0] & 8'h7F) : w[7:0];
        end
      end
    end
    fc = 1'b0;
    @(posedge sclk); #2;
    m_strb = 1'b0;
    repeat (GAP) @(posedge sclk);
    #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
    do_frame(16'h0000, 1'b1, "R5 req");
    do_frame({3'b000, a, d}, 1'b0, tag);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    do_frame(16'h0000, 1'b1, "R5 req");
    do_frame({3'b001, a, 8'h00}, 1'b0, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    repeat (3) @(posedge sclk);
    #7;
    // R14 reset state
    chk("R14 oe", 16'(dout_oe), 16'h0);
    chk("R14 dac", dac_data, 16'h0);
    chk("R14 strb", 16'(dac_strb), 16'h0);
    chk("R14 rate", 16'(rdiv), 16'h1);
    chk("R14 flag", 16'(flag), 16'h0);
    @(posedge sclk); #2;
    rst_n = 1'b1; run = 1;
    repeat (2) @(posedge sclk); #2;

    adc_val = 16'h1235;
    do_frame(16'hA5A4, 1'b0, "R3 adc15");      // ADC LSB masked
    chk("R4 dac word", dac_data, 16'hA5A4);
    do_frame(16'h7FFF, 1'b0, "R6 lsb req");    // 15+1 DAC: LSB requests
    chk("R4 dac mask", dac_data, 16'h7FFE);
    do_frame({3'b000, 5'd2, 8'h03}, 1'b0, "R7 wr ctrl2"); // data LSB=1, R10
    chk("R12 flag", 16'(flag), 16'h1);
    do_frame(16'h1000, 1'b1, "R10 primary after sec");
    do_frame({3'b001, 5'd2, 8'h00}, 1'b0, "R8 rd ctrl2");
    adc_val = 16'h8001;
    do_frame(16'h0002, 1'b0, "R3 adc16");
    wr(5'd1, 8'h03, "R7 wr ctrl1");
    do_frame(16'h4321, 1'b0, "R6 no req 16b");
    chk("R4 dac 16b", dac_data, 16'h4321);
    do_frame(16'h0000, 1'b0, "R11 loopback");
    wr(5'd5, 8'hFF, "R9 wr reserved");
    rd(5'd5, "R9 rd reserved");
    wr(5'd0, 8'hFF, "R9 wr nop");
    wr(5'd9, 8'hFF, "R9 wr high addr");
    rd(5'd2, "R9 ctrl2 kept");
    do_frame(16'h0000, 1'b1, "R5 req");
    do_frame({3'b100, 5'd4, 8'h5A}, 1'b0, "R7 bad prefix");
    rd(5'd4, "R7 ctrl4 kept");
    do_frame(16'h0000, 1'b1, "R5 req");
    do_frame({3'b011, 5'd2, 8'h00}, 1'b0, "R8 bad read");
    wr(5'd4, 8'hB5, "R7 wr ctrl4");
    chk("R12 rate", 16'(rdiv), 16'd6);
    chk("R12 gain", 16'(gain), 16'd6);
    chk("R12 pll", 16'(pllby), 16'd1);
    wr(5'd3, 8'h3C, "R7 wr ctrl3");
    chk("R12 chain", 16'(chain), 16'h003C);
    rd(5'd1, "R8 rd ctrl1");
    wr(5'd1, 8'h80, "R13 soft reset");
    chk("R13 rate", 16'(rdiv), 16'd1);
    chk("R13 flag", 16'(flag), 16'd0);
    chk("R13 chain", 16'(chain), 16'd0);
    rd(5'd1, "R13 rd ctrl1");
    adc_val = 16'hFFFF;
    do_frame(16'h0001, 1'b0, "R3 adc15 again");  // also R6 request
    do_frame(16'h0000, 1'b0, "R8 no read");
    do_frame(16'h2468, 1'b0, "R4 final");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sclk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule